// File: doc/BRIEF.md
# Interrupt Message Ring Writer

This block turns inbound message-signalled interrupts into 16-byte records and writes them into a circular buffer in system memory. Each record carries the interrupt number in its lowest four bytes, little-endian, and zeros in the rest. Records go out through a memory-write request port with a valid/ready handshake. The address of each record is the 64-bit buffer base plus the current write offset.

Software sets the block up through a small word-indexed register port. Through that port it programs the buffer base, the buffer size and the mode bits. It consumes records by moving the read offset forward. A level interrupt to the host stays high while unread records exist, or while the buffer is full and full signalling is on. When the buffer is full, the block does one of two things. If stop-on-full is set, it stalls the inbound port. Otherwise it drops the message and sets a sticky overflow flag.

Top module: `msiq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `host_irq`, `msg_ready` and `mem_valid` are low.
- R2: The register indices are: 0 control, 3 base high (address bits 63:32), 4 base low (bits 31:0), 5 read offset, 6 write offset. Every other index reads zero. `reg_rdata` shows the register selected by `reg_addr` one cycle later. The control bits are: 0 enable, 1 full signalling, 3 interrupt enable, 4 stop-on-full, 9:8 size select, 16 overflow.
- R3: The buffer size is 2^(15+select) bytes. An offset written by software is stored ANDed with (size-1) & ~0xF.
- R4: Each message accepted while the buffer is not full produces one memory write. Its address is {base high, base low} + write offset, using a full 64-bit add. Its data has the interrupt number in bits 31:0 and zero in bits 127:32. Address and data hold steady until `mem_ready`.
- R5: When the memory port accepts a record, the write offset moves forward by 16, modulo the buffer size.
- R6: The buffer is full when (write offset + 16) mod size equals the read offset. `host_irq` is registered. It equals enable AND ((interrupt enable AND read offset != write offset) OR (full signalling AND full)).
- R7: When the buffer is full and stop-on-full is set, `msg_ready` is low.
- R8: When the buffer is full and stop-on-full is clear, a message is accepted but no memory write follows, and overflow (control bit 16) becomes 1. Writing the control register with bit 16 set clears overflow.
- R9: With enable clear, `msg_ready` and `host_irq` are low.
- R10: Only one record is outstanding at a time: `msg_ready` is low while `mem_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| msg_valid | input | 1 | Inbound interrupt message present |
| msg_ready | output | 1 | Block can take a message |
| msg_irq | input | 32 | Interrupt number of the message |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
A wrong write offset shows up at the next record: its `mem_addr` is off by a multiple of 16. Reading index 6 after each batch exposes the same error without waiting. A wrong full decision shows at once: either `msg_ready` stays high where it must stall, or a record reaches memory where a drop and an overflow flag were due. A wrong interrupt term appears at `host_irq` two cycles after the register write or record that changed the offsets. The bench places the offsets across the wrap point and adds a base-low value that carries into the high word, so that address and modulo errors become visible.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  // Register word indices
  localparam logic [2:0] IDX_CTRL    = 3'd0;
  localparam logic [2:0] IDX_BASE_HI = 3'd3;
  localparam logic [2:0] IDX_BASE_LO = 3'd4;
  localparam logic [2:0] IDX_RD_OFS  = 3'd5;
  localparam logic [2:0] IDX_WR_OFS  = 3'd6;

  // Control word bit positions
  localparam int CB_EN      = 0;
  localparam int CB_FULLSIG = 1;
  localparam int CB_IRQEN   = 3;
  localparam int CB_STOP    = 4;
  localparam int CB_SIZE    = 8;
  localparam int CB_OVF     = 16;

  typedef struct packed {
    logic en;
    logic full_sig;
    logic irq_en;
    logic stop_full;
  } ctrl_bits_t;
endpackage

// File: rtl/msiq_ring.sv
module msiq_ring #(
  parameter int OFS_W    = 18,
  parameter int MIN_LOG2 = 15,
  parameter int SEL_W    = 2,
  parameter int REC_LOG2 = 4
) (
  input  logic [SEL_W-1:0] size_sel,
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic [OFS_W-1:0] wr_ofs,
  output logic [OFS_W-1:0] ofs_mask,
  output logic [OFS_W-1:0] wr_next,
  output logic             empty,
  output logic             full
);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(1) << REC_LOG2;

  // Offset mask: record-aligned bits below the selected size
  for (genvar b = 0; b < OFS_W; b++) begin : g_mask
    if (b < REC_LOG2) begin : g_low
      assign ofs_mask[b] = 1'b0;
    end else begin : g_high
      assign ofs_mask[b] = (int'(size_sel) + MIN_LOG2) > b;
    end
  end

  assign wr_next = (wr_ofs + STEP) & ofs_mask;
  assign empty   = (wr_ofs == rd_ofs);
  assign full    = (wr_next == rd_ofs);
endmodule

// File: rtl/msiq_regs.sv
module msiq_regs
  import msiq_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int OFS_W = 18,
  parameter int SEL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [OFS_W-1:0]   ofs_mask,
  input  logic               hw_adv,
  input  logic [OFS_W-1:0]   hw_wr_next,
  input  logic               ovf_set,
  output ctrl_bits_t         ctrl,
  output logic [SEL_W-1:0]   size_sel,
  output logic [2*REG_W-1:0] base,
  output logic [OFS_W-1:0]   rd_ofs,
  output logic [OFS_W-1:0]   wr_ofs
);
  logic             ovf;
  logic [REG_W-1:0] base_hi, base_lo;
  logic [REG_W-1:0] rd_mux;
  logic             hit_ctrl, hit_hi, hit_lo, hit_rd, hit_wr;

  assign hit_ctrl = reg_wr && (reg_addr == IDX_CTRL);
  assign hit_hi   = reg_wr && (reg_addr == IDX_BASE_HI);
  assign hit_lo   = reg_wr && (reg_addr == IDX_BASE_LO);
  assign hit_rd   = reg_wr && (reg_addr == IDX_RD_OFS);
  assign hit_wr   = reg_wr && (reg_addr == IDX_WR_OFS);
  assign base     = {base_hi, base_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      size_sel <= '0;
      ovf      <= 1'b0;
      base_hi  <= '0;
      base_lo  <= '0;
      rd_ofs   <= '0;
      wr_ofs   <= '0;
    end else begin
      if (hit_ctrl) begin
        ctrl.en        <= reg_wdata[CB_EN];
        ctrl.full_sig  <= reg_wdata[CB_FULLSIG];
        ctrl.irq_en    <= reg_wdata[CB_IRQEN];
        ctrl.stop_full <= reg_wdata[CB_STOP];
        size_sel       <= reg_wdata[CB_SIZE +: SEL_W];
      end
      if (ovf_set)
        ovf <= 1'b1;
      else if (hit_ctrl && reg_wdata[CB_OVF])
        ovf <= 1'b0;
      if (hit_hi) base_hi <= reg_wdata;
      if (hit_lo) base_lo <= reg_wdata;
      if (hit_rd) rd_ofs <= reg_wdata[OFS_W-1:0] & ofs_mask;
      if (hit_wr)
        wr_ofs <= reg_wdata[OFS_W-1:0] & ofs_mask;
      else if (hw_adv)
        wr_ofs <= hw_wr_next;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      IDX_CTRL: begin
        rd_mux[CB_EN]             = ctrl.en;
        rd_mux[CB_FULLSIG]        = ctrl.full_sig;
        rd_mux[CB_IRQEN]          = ctrl.irq_en;
        rd_mux[CB_STOP]           = ctrl.stop_full;
        rd_mux[CB_SIZE +: SEL_W]  = size_sel;
        rd_mux[CB_OVF]            = ovf;
      end
      IDX_BASE_HI: rd_mux = base_hi;
      IDX_BASE_LO: rd_mux = base_lo;
      IDX_RD_OFS:  rd_mux = {{(REG_W-OFS_W){1'b0}}, rd_ofs};
      IDX_WR_OFS:  rd_mux = {{(REG_W-OFS_W){1'b0}}, wr_ofs};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/msiq_capture.sv
module msiq_capture #(
  parameter int IRQ_W  = 32,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128,
  parameter int OFS_W  = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              stop_full,
  input  logic              full,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [IRQ_W-1:0]  msg_irq,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              hw_adv,
  output logic              ovf_set
);
  logic take;

  assign msg_ready = enable && !mem_valid && !(full && stop_full);
  assign take      = msg_valid && msg_ready;
  assign hw_adv    = mem_valid && mem_ready;
  assign ovf_set   = take && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (hw_adv) begin
      mem_valid <= 1'b0;
    end else if (take && !full) begin
      mem_valid <= 1'b1;
      mem_addr  <= base + {{(ADDR_W-OFS_W){1'b0}}, wr_ofs};
      mem_data  <= {{(DATA_W-IRQ_W){1'b0}}, msg_irq};
    end
  end
endmodule

// File: rtl/msiq_ctrl.sv
module msiq_ctrl
  import msiq_pkg::*;
#(
  parameter int IRQ_W    = 32,
  parameter int REG_W    = 32,
  parameter int MIN_LOG2 = 15,
  parameter int SEL_W    = 2,
  parameter int REC_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [IRQ_W-1:0]   msg_irq,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [(8<<REC_LOG2)-1:0] mem_data,
  output logic               host_irq
);
  localparam int ADDR_W = 2 * REG_W;
  localparam int DATA_W = 8 << REC_LOG2;
  localparam int OFS_W  = MIN_LOG2 + (1 << SEL_W) - 1;

  ctrl_bits_t        ctrl;
  logic [SEL_W-1:0]  size_sel;
  logic [ADDR_W-1:0] base;
  logic [OFS_W-1:0]  rd_ofs, wr_ofs, ofs_mask, wr_next;
  logic              empty, full, hw_adv, ovf_set;

  msiq_regs #(.REG_W(REG_W), .OFS_W(OFS_W), .SEL_W(SEL_W)) u_regs (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ofs_mask, .hw_adv, .hw_wr_next(wr_next), .ovf_set,
    .ctrl, .size_sel, .base, .rd_ofs, .wr_ofs
  );

  msiq_ring #(.OFS_W(OFS_W), .MIN_LOG2(MIN_LOG2), .SEL_W(SEL_W),
              .REC_LOG2(REC_LOG2)) u_ring (
    .size_sel, .rd_ofs, .wr_ofs, .ofs_mask, .wr_next, .empty, .full
  );

  msiq_capture #(.IRQ_W(IRQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .OFS_W(OFS_W)) u_cap (
    .clk, .rst, .enable(ctrl.en), .stop_full(ctrl.stop_full), .full,
    .base, .wr_ofs, .msg_valid, .msg_ready, .msg_irq,
    .mem_valid, .mem_ready, .mem_addr, .mem_data, .hw_adv, .ovf_set
  );

  always_ff @(posedge clk) begin
    if (rst) host_irq <= 1'b0;
    else     host_irq <= ctrl.en && ((ctrl.irq_en && !empty) ||
                                     (ctrl.full_sig && full));
  end
endmodule

// File: rtl/msiq_ctrl_chk.sv
module msiq_ctrl_chk #(
  parameter int OFS_W  = 18,
  parameter int IRQ_W  = 32,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic              msg_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              host_irq,
  input logic              ctrl_en,
  input logic              ctrl_stop,
  input logic              ring_full,
  input logic [OFS_W-1:0]  rd_ofs,
  input logic [OFS_W-1:0]  wr_ofs
);
  logic sw_wr_ofs;
  assign sw_wr_ofs = reg_wr && (reg_addr == 3'd6);

  // R4: request held until accepted
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  // R4: upper record bytes are zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_data[DATA_W-1:IRQ_W] == '0);

  // R3: offsets stay record aligned
  p_align_r3: assert property (@(posedge clk) disable iff (rst)
    rd_ofs[3:0] == 4'd0 && wr_ofs[3:0] == 4'd0);

  // R7: no intake while full with stop-on-full
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    ring_full && ctrl_stop |-> !msg_ready);

  // R10: one outstanding record
  p_one_out_r10: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !msg_ready);

  // R9: disabled block keeps interrupt low
  p_dis_irq_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !host_irq);

  // R5: write offset moves only on memory accept or software write
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && mem_ready) && !sw_wr_ofs |=> $stable(wr_ofs));

  p_wr_move_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_ready && !sw_wr_ofs |=> wr_ofs != $past(wr_ofs));
endmodule

bind msiq_ctrl msiq_ctrl_chk #(
  .OFS_W(OFS_W), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .msg_ready(msg_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .host_irq(host_irq),
  .ctrl_en(ctrl.en), .ctrl_stop(ctrl.stop_full), .ring_full(full),
  .rd_ofs(rd_ofs), .wr_ofs(wr_ofs)
);

// File: tb/sim_msiq_ctrl.sv
module sim_msiq_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst = 1'b1;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = 3'd0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msg_valid = 1'b0;
  logic         msg_ready;
  logic [31:0]  msg_irq = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         host_irq;

  msiq_ctrl u0 (
    .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .msg_valid, .msg_ready, .msg_irq,
    .mem_valid, .mem_ready, .mem_addr, .mem_data, .host_irq
  );

  int checks = 0, errors = 0, rec_count = 0;
  logic [31:0] exp_irq = '0;
  logic [63:0] base_m = '0;
  int unsigned rd_m = 0, wr_m = 0, sel_m = 0;
  bit stall_mem = 1'b0;

  function automatic int unsigned msk(int unsigned sel);
    return ((32'd1 << (15 + sel)) - 32'd1) & ~32'hF;
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder and record checker
  always @(negedge clk) begin
    if (rst) mem_ready = 1'b0;
    else begin
      mem_ready = stall_mem ? 1'b0 : ($urandom % 3 != 0);
      if (mem_valid && mem_ready) begin
        chk(mem_addr == base_m + 64'(wr_m), "R4 record address", mem_addr, base_m + 64'(wr_m));
        chk(mem_data == {96'd0, exp_irq}, "R4 record data", mem_data, {96'd0, exp_irq});
        wr_m = (wr_m + 16) & msk(sel_m);
        rec_count++;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    if (a == 3'd0) sel_m = d[9:8];
    if (a == 3'd5) rd_m = d & msk(sel_m);
    if (a == 3'd6) wr_m = d & msk(sel_m);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] irq, output bit took);
    int guard = 0;
    @(negedge clk); msg_valid = 1'b1; msg_irq = irq; exp_irq = irq;
    while (!msg_ready && guard < 50) begin @(negedge clk); guard++; end
    took = msg_ready;
    @(negedge clk); msg_valid = 1'b0;
    while (mem_valid) @(negedge clk);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit took;
    int n;
    void'($urandom(32'h5EED_0017));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(host_irq == 0 && msg_ready == 0 && mem_valid == 0, "R1 outputs", {host_irq, msg_ready, mem_valid}, 0);
    foreach (d[i]) begin end
    rd_reg(3'd0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd_reg(3'd3, d); chk(d == 0, "R1 base hi", d, 0);
    rd_reg(3'd4, d); chk(d == 0, "R1 base lo", d, 0);
    rd_reg(3'd5, d); chk(d == 0, "R1 rd ofs", d, 0);
    rd_reg(3'd6, d); chk(d == 0, "R1 wr ofs", d, 0);

    // R2 configuration and readback
    base_m = 64'h0000_0012_FFFF_C000;
    wr_reg(3'd3, base_m[63:32]);
    wr_reg(3'd4, base_m[31:0]);
    wr_reg(3'd0, 32'h0000_0009);
    rd_reg(3'd0, d); chk(d == 32'h9, "R2 ctrl readback", d, 32'h9);
    rd_reg(3'd3, d); chk(d == 32'h12, "R2 base hi", d, 32'h12);
    rd_reg(3'd4, d); chk(d == 32'hFFFF_C000, "R2 base lo", d, 32'hFFFF_C000);
    rd_reg(3'd1, d); chk(d == 0, "R2 unused index", d, 0);

    // R4 / R5 directed records
    send(32'h5, took);
    send(32'hDEAD_BEEF, took);
    send(32'h0, took);
    rd_reg(3'd6, d); chk(d == 32'h30, "R5 wr ofs after 3", d, 32'h30);
    settle(); chk(host_irq == 1, "R6 irq pending", host_irq, 1);

    // R6 consume clears interrupt
    wr_reg(3'd5, 32'h30); settle();
    chk(host_irq == 0, "R6 irq after consume", host_irq, 0);

    // R3 offset masking
    wr_reg(3'd5, 32'h0001_234F);
    rd_reg(3'd5, d); chk(d == 32'h2340, "R3 rd ofs mask", d, 32'h2340);
    wr_reg(3'd5, 32'h30);

    // R10 / R4 stalled memory
    stall_mem = 1'b1;
    @(negedge clk); msg_valid = 1'b1; msg_irq = 32'h77; exp_irq = 32'h77;
    @(negedge clk); msg_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_valid == 1 && msg_ready == 0, "R10 one outstanding", {mem_valid, msg_ready}, 2'b10);
    chk(mem_addr == base_m + 64'h30, "R4 held address", mem_addr, base_m + 64'h30);
    stall_mem = 1'b0;
    while (mem_valid) @(negedge clk);

    // R7 stop-on-full near wrap with carry into high word
    wr_reg(3'd6, 32'h7FE0);
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd0, 32'h19);
    send(32'h100, took);
    rd_reg(3'd6, d); chk(d == 32'h7FF0, "R5 wr ofs advance", d, 32'h7FF0);
    send(32'h101, took);
    chk(took == 0, "R7 stall when full", took, 0);
    rd_reg(3'd6, d); chk(d == 32'h7FF0, "R7 wr ofs unchanged", d, 32'h7FF0);

    // R6 full signalling
    wr_reg(3'd0, 32'h13); settle();
    chk(host_irq == 1, "R6 full signal irq", host_irq, 1);
    wr_reg(3'd0, 32'h11); settle();
    chk(host_irq == 0, "R6 no irq terms", host_irq, 0);

    // R8 drop with overflow flag
    wr_reg(3'd0, 32'h09);
    n = rec_count;
    send(32'h102, took);
    chk(took == 1, "R8 drop accepted", took, 1);
    chk(rec_count == n, "R8 no record", rec_count, n);
    rd_reg(3'd0, d); chk(d == 32'h10009, "R8 overflow set", d, 32'h10009);
    wr_reg(3'd0, 32'h10009);
    rd_reg(3'd0, d); chk(d == 32'h9, "R8 overflow cleared", d, 32'h9);

    // R5 wrap at 32 KB
    wr_reg(3'd5, 32'h10);
    send(32'h103, took);
    rd_reg(3'd6, d); chk(d == 0, "R5 wrap 32K", d, 0);

    // R3 64 KB size
    wr_reg(3'd0, 32'h109);
    wr_reg(3'd6, 32'hFFF0);
    wr_reg(3'd5, 32'h20);
    send(32'h104, took);
    rd_reg(3'd6, d); chk(d == 0, "R3 wrap 64K", d, 0);
    settle(); chk(host_irq == 1, "R6 irq before disable", host_irq, 1);

    // R9 disable
    wr_reg(3'd0, 32'h0); settle();
    chk(host_irq == 0 && msg_ready == 0, "R9 disabled", {host_irq, msg_ready}, 0);

    // Random phase
    wr_reg(3'd6, 32'h0);
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd0, 32'h0B);
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 5 == 0) begin
        wr_reg(3'd5, wr_m); settle();
        chk(host_irq == 0, "R6 random consume", host_irq, 0);
      end else begin
        bit full_m;
        full_m = (((wr_m + 16) & msk(sel_m)) == rd_m);
        n = rec_count;
        send($urandom, took);
        chk(rec_count == n + (full_m ? 0 : 1), "R4 random record count", rec_count, n + (full_m ? 0 : 1));
      end
      if (i % 50 == 49) begin
        rd_reg(3'd6, d); chk(d == wr_m, "R5 random wr ofs", d, wr_m);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule